// File: doc/BRIEF.md
# Receive Descriptor Chaining Engine

This block moves the bytes of an incoming network frame into host memory buffers. The buffers are described by a ring of two-word receive descriptors. For each frame the engine fetches the descriptor at its current ring position and checks that the device owns it. It then stores bytes at consecutive addresses in that descriptor's buffer. When the buffer is full and more bytes remain, it takes the next descriptor in the ring. Every descriptor it fills gets one status word written back, which also hands ownership back to the host.

The status word carries first-buffer and last-buffer markers and a set of error flags. Each flag has its own rule for when it may appear. The engine stalls the byte stream through `rx_ready` while it fetches a descriptor or writes status back. When a frame cannot be stored, it accepts and discards the rest of that frame. The ring base address and the number of entries come from configuration inputs. The memory port is a single synchronous port with a one-cycle read latency.

Top module: `rx_desc_chain`

## Requirements
- R1: Descriptor i sits at `cfg_ring_base + 8*i`. Word 0 is the buffer address and word 1 (at +4) holds status and count. Word 1 bits: 31 ownership (1 = device), 30 summary error, 29 framing, 28 overflow, 27 FCS error, 26 buffer error, 25 first buffer, 24 last buffer. The written word has bits 23:16 zero, bits 15:12 all ones, and bits 11:0 equal to the count that was read. Word 0 is never written.
- R2: A buffer's capacity is the two's complement of its 12-bit count field, with a field of 0 meaning 4096. Frame bytes are stored in order at the buffer address plus their offset in that buffer. The engine moves to another buffer only when the current one is full and another byte is waiting.
- R3: Bit 30 of every written status word equals the OR of bits 29, 28, 27 and 26.
- R4: The first buffer of a frame has bit 25 set and the last has bit 24 set. A frame that fits in one buffer, including one that fills it exactly, uses one descriptor with both bits set.
- R5: In the last buffer of a frame, bit 27 is set when the FCS error flag came with the final byte. Bit 29 is set only when the FCS error and dribble flags both came with the final byte. A dribble flag alone sets neither bit.
- R6: Status is written back as a single word write with bit 31 cleared. It is written only after every byte stored in that buffer has been written.
- R7: If the descriptor at a frame start is host-owned, the engine writes nothing to it and pulses `missed_frame` for exactly one cycle. It discards the frame, and the next frame starts at the same descriptor.
- R8: If the next descriptor is host-owned when a frame needs another buffer, the current descriptor is written with bits 26 and 30 set and bit 24 clear. The engine discards the rest of the frame and never writes the next descriptor. The next frame starts at that next descriptor.
- R9: An overflow while bytes are being stored into a buffer that still has room writes that descriptor with bits 28 and 30 set and bit 24 clear. The engine discards the rest of the frame, and the next frame starts at the following descriptor.
- R10: An overflow while the next descriptor's status is being fetched reports bit 26 only, and the fetched descriptor is left untouched. Bit 28 is added only when the overflow occurs in the same cycle as a host-owned next descriptor is detected.
- R11: The ring position wraps from entry `cfg_ring_size-1` to entry 0.
- R12: `rx_ready` is low after reset, while idle and during every descriptor read. Discarded bytes are accepted with `rx_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ring_base | input | ADDR_W | Byte address of descriptor 0 |
| cfg_ring_size | input | IDX_W+1 | Number of descriptors in the ring |
| rx_valid | input | 1 | Frame byte present |
| rx_ready | output | 1 | Byte accepted at this edge when high with rx_valid |
| rx_data | input | 8 | Frame byte |
| rx_last | input | 1 | Final byte of the frame |
| rx_fcs_err | input | 1 | FCS check failed, valid with rx_last |
| rx_dribble | input | 1 | Frame ended on a partial byte, valid with rx_last |
| fifo_ovf | input | 1 | Internal FIFO overflow indication |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Access is a write |
| mem_byte | output | 1 | Write is a single byte in mem_wdata[7:0] |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after the read request |
| missed_frame | output | 1 | One-cycle pulse when a frame is dropped for lack of a buffer |

## Verification
The stored-frame path is driven with frames of lengths 1, 5 and 10, with a length that fills a buffer exactly, and with lengths of one byte over and of several buffers. These separate single-buffer marking from chaining and show the ring wrap. The FCS and dribble flags are tried alone and together at the frame end, which shows whether the framing bit needs both. Fault runs separate a host-owned descriptor at frame start from one found mid-chain. They also place an overflow during byte storage, in the read cycle of the next descriptor, and in the cycle its ownership is seen, so that OFLO, BUFF and the combined report can each be told apart.

// File: rtl/rxdesc_pkg.sv
package rxdesc_pkg;

    localparam int BCNT_W = 12;
    localparam int LEN_W  = BCNT_W + 1;
    localparam int WORD_W = 32;

    localparam logic [LEN_W-1:0] FULL_LEN = {1'b1, {BCNT_W{1'b0}}};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_STAT,
        ST_CHK_STAT,
        ST_RD_ADDR,
        ST_GET_ADDR,
        ST_DATA,
        ST_WB,
        ST_DROP
    } rx_state_e;

    typedef struct packed {
        logic fram;
        logic oflo;
        logic crc;
        logic buff;
        logic stp;
        logic enp;
    } rx_flags_t;

endpackage

// File: rtl/rxdesc_status_pack.sv
module rxdesc_status_pack
    import rxdesc_pkg::*;
(
    input  rx_flags_t           flags,
    input  logic [BCNT_W-1:0]   bcnt,
    output logic [WORD_W-1:0]   word
);

    logic err;

    always_comb begin
        err  = flags.fram | flags.oflo | flags.crc | flags.buff;
        word = {1'b0, err, flags.fram, flags.oflo, flags.crc, flags.buff,
                flags.stp, flags.enp, 8'h00, 4'hF, bcnt};
    end

endmodule

// File: rtl/rxdesc_ring_index.sv
module rxdesc_ring_index #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] ring_base,
    input  logic [IDX_W:0]    ring_size,
    input  logic [IDX_W-1:0]  cur_idx,
    input  logic [IDX_W-1:0]  nxt_idx,
    input  logic              sel_nxt,
    output logic [IDX_W-1:0]  cur_succ,
    output logic [ADDR_W-1:0] desc_addr
);

    logic [IDX_W:0]   cur_plus;
    logic [IDX_W-1:0] sel_idx;

    always_comb begin
        cur_plus  = {1'b0, cur_idx} + 1'b1;
        cur_succ  = (cur_plus >= ring_size) ? '0 : cur_plus[IDX_W-1:0];
        sel_idx   = sel_nxt ? nxt_idx : cur_idx;
        desc_addr = ring_base + (ADDR_W'(sel_idx) << 3);
    end

endmodule

// File: rtl/rx_desc_chain.sv
module rx_desc_chain
    import rxdesc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cfg_ring_base,
    input  logic [IDX_W:0]    cfg_ring_size,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_last,
    input  logic              rx_fcs_err,
    input  logic              rx_dribble,
    input  logic              fifo_ovf,
    output logic              mem_en,
    output logic              mem_we,
    output logic              mem_byte,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              missed_frame
);

    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(4);

    typedef struct packed {
        rx_state_e          st;
        rx_state_e          wb_next;
        logic [IDX_W-1:0]   cur;
        logic [IDX_W-1:0]   nxt;
        logic [IDX_W-1:0]   wb_idx;
        logic [BCNT_W-1:0]  bcnt;
        logic [BCNT_W-1:0]  nbcnt;
        logic [ADDR_W-1:0]  buf_addr;
        logic [LEN_W-1:0]   cnt;
        logic               first;
        logic               chain;
        logic               ovf_seen;
        rx_flags_t          flags;
    } regs_t;

    regs_t q, d;

    logic [IDX_W-1:0]  cur_succ;
    logic [ADDR_W-1:0] desc_addr;
    logic [WORD_W-1:0] stat_word;
    logic [LEN_W-1:0]  buf_len;
    logic              room;
    logic              sel_nxt;
    logic              nxt_bad;

    assign sel_nxt = (q.st == ST_RD_STAT) && q.chain;

    rxdesc_ring_index #(
        .ADDR_W (ADDR_W),
        .IDX_W  (IDX_W)
    ) i_ring_index (
        .ring_base (cfg_ring_base),
        .ring_size (cfg_ring_size),
        .cur_idx   (q.cur),
        .nxt_idx   (q.nxt),
        .sel_nxt   (sel_nxt),
        .cur_succ  (cur_succ),
        .desc_addr (desc_addr)
    );

    rxdesc_status_pack i_status_pack (
        .flags (q.flags),
        .bcnt  (q.bcnt),
        .word  (stat_word)
    );

    assign buf_len = FULL_LEN - {1'b0, q.bcnt};
    assign room    = q.cnt < buf_len;

    always_comb begin
        d            = q;
        rx_ready     = 1'b0;
        mem_en       = 1'b0;
        mem_we       = 1'b0;
        mem_byte     = 1'b0;
        mem_addr     = '0;
        mem_wdata    = '0;
        missed_frame = 1'b0;
        nxt_bad      = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (rx_valid) begin
                    d.st    = ST_RD_STAT;
                    d.chain = 1'b0;
                    d.first = 1'b1;
                end
            end

            ST_RD_STAT: begin
                mem_en     = 1'b1;
                mem_addr   = desc_addr + STAT_OFS;
                d.ovf_seen = q.chain & fifo_ovf;
                d.st       = ST_CHK_STAT;
            end

            ST_CHK_STAT: begin
                if (!q.chain) begin
                    if (mem_rdata[31]) begin
                        d.bcnt = mem_rdata[BCNT_W-1:0];
                        d.st   = ST_RD_ADDR;
                    end else begin
                        missed_frame = 1'b1;
                        d.st         = ST_DROP;
                    end
                end else begin
                    nxt_bad          = !mem_rdata[31] || q.ovf_seen || fifo_ovf;
                    d.flags          = '0;
                    d.flags.stp      = q.first;
                    d.wb_idx         = q.nxt;
                    if (nxt_bad) begin
                        d.flags.buff = 1'b1;
                        d.flags.oflo = !mem_rdata[31] && fifo_ovf;
                        d.wb_next    = ST_DROP;
                    end else begin
                        d.nbcnt      = mem_rdata[BCNT_W-1:0];
                        d.wb_next    = ST_RD_ADDR;
                    end
                    d.st             = ST_WB;
                end
            end

            ST_RD_ADDR: begin
                mem_en   = 1'b1;
                mem_addr = desc_addr;
                d.st     = ST_GET_ADDR;
            end

            ST_GET_ADDR: begin
                d.buf_addr = mem_rdata[ADDR_W-1:0];
                d.cnt      = '0;
                d.st       = ST_DATA;
            end

            ST_DATA: begin
                rx_ready = room;
                if (fifo_ovf) begin
                    d.flags     = '0;
                    d.flags.stp = q.first;
                    d.wb_idx    = cur_succ;
                    d.st        = ST_WB;
                    if (room) begin
                        d.flags.oflo = 1'b1;
                    end else begin
                        d.flags.buff = 1'b1;
                    end
                    d.wb_next = (rx_valid && rx_last && room) ? ST_IDLE : ST_DROP;
                end else if (rx_valid && room) begin
                    mem_en    = 1'b1;
                    mem_we    = 1'b1;
                    mem_byte  = 1'b1;
                    mem_addr  = q.buf_addr + ADDR_W'(q.cnt);
                    mem_wdata = {{(WORD_W-8){1'b0}}, rx_data};
                    d.cnt     = q.cnt + 1'b1;
                    if (rx_last) begin
                        d.flags      = '0;
                        d.flags.stp  = q.first;
                        d.flags.enp  = 1'b1;
                        d.flags.crc  = rx_fcs_err;
                        d.flags.fram = rx_fcs_err & rx_dribble;
                        d.wb_idx     = cur_succ;
                        d.wb_next    = ST_IDLE;
                        d.st         = ST_WB;
                    end
                end else if (rx_valid) begin
                    d.chain = 1'b1;
                    d.nxt   = cur_succ;
                    d.st    = ST_RD_STAT;
                end
            end

            ST_WB: begin
                mem_en    = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = desc_addr + STAT_OFS;
                mem_wdata = stat_word;
                d.cur     = q.wb_idx;
                d.first   = 1'b0;
                d.chain   = 1'b0;
                if (q.wb_next == ST_RD_ADDR) begin
                    d.bcnt = q.nbcnt;
                end
                d.st = q.wb_next;
            end

            ST_DROP: begin
                rx_ready = 1'b1;
                if (rx_valid && rx_last) begin
                    d.st = ST_IDLE;
                end
            end

            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q         <= '0;
            q.st      <= ST_IDLE;
            q.wb_next <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    AST_STAT_LAYOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !mem_byte) |->
        (!mem_wdata[31] && mem_wdata[23:16] == 8'h00 && mem_wdata[15:12] == 4'hF)); // R1

    AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !mem_byte) |->
        (mem_wdata[30] == (|mem_wdata[29:26]))); // R3

    AST_FCS_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !mem_byte && (mem_wdata[27] || mem_wdata[29])) |->
        (mem_wdata[24] && !mem_wdata[28])); // R5

    AST_OFLO_NOT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we && !mem_byte && mem_wdata[28]) |-> !mem_wdata[24]); // R9

    AST_MISS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        missed_frame |=> !missed_frame); // R7

    AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        missed_frame |=> !mem_en); // R7

    AST_FETCH_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> !rx_ready); // R12

    AST_IDX_IN_RING: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ring_size != '0) |-> ({1'b0, q.cur} < cfg_ring_size)); // R11

endmodule

// File: tb/test_rx_desc_chain.sv
`timescale 1ns/1ps
module test_rx_desc_chain;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] cfg_ring_base = 32'h0;
    logic [8:0]  cfg_ring_size = 9'd4;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = 8'h00;
    logic        rx_last = 1'b0;
    logic        rx_fcs_err = 1'b0;
    logic        rx_dribble = 1'b0;
    logic        ovf_a = 1'b0;
    logic        ovf_b = 1'b0;
    logic        fifo_ovf;
    logic        mem_en, mem_we, mem_byte;
    logic [31:0] mem_addr, mem_wdata;
    logic [31:0] mem_rdata = 32'h0;
    logic        missed_frame;

    assign fifo_ovf = ovf_a | ovf_b;

    always #4 clk = ~clk;

    rx_desc_chain i_rx_desc_chain (
        .clk(clk), .rst_n(rst_n),
        .cfg_ring_base(cfg_ring_base), .cfg_ring_size(cfg_ring_size),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_last(rx_last), .rx_fcs_err(rx_fcs_err), .rx_dribble(rx_dribble),
        .fifo_ovf(fifo_ovf),
        .mem_en(mem_en), .mem_we(mem_we), .mem_byte(mem_byte),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .missed_frame(missed_frame)
    );

    // memory model, host writes and write logging
    logic [31:0] mem [0:255];
    int          bufcnt [4];
    int          wbcnt  [4];
    int          wbnum  [4];
    int          miss_cnt = 0;
    logic        hw_en = 1'b0;
    logic [31:0] hw_addr = 32'h0;
    logic [31:0] hw_data = 32'h0;

    always @(posedge clk) begin
        if (missed_frame) miss_cnt <= miss_cnt + 1;
        if (hw_en) begin
            mem[hw_addr[9:2]] <= hw_data;
            if (hw_addr < 32 && hw_addr[2]) begin
                bufcnt[hw_addr[4:3]] <= 0;
                wbnum[hw_addr[4:3]]  <= 0;
                wbcnt[hw_addr[4:3]]  <= 0;
            end
        end
        if (mem_en) begin
            if (!mem_we) begin
                mem_rdata <= mem[mem_addr[9:2]];
            end else if (mem_byte) begin
                mem[mem_addr[9:2]][mem_addr[1:0]*8 +: 8] <= mem_wdata[7:0];
                bufcnt[mem_addr[6:5]] <= bufcnt[mem_addr[6:5]] + 1;
            end else begin
                mem[mem_addr[9:2]] <= mem_wdata;
                if (mem_addr < 32) begin
                    wbcnt[mem_addr[4:3]] <= bufcnt[mem_addr[4:3]];
                    wbnum[mem_addr[4:3]] <= wbnum[mem_addr[4:3]] + 1;
                end
            end
        end
    end

    // overflow injector keyed on a descriptor status read
    int          inj_req = 0;
    int          inj_ack = 0;
    logic [31:0] inj_addr = 32'h0;
    logic        inj_in_rd = 1'b0;
    logic        inj_pend = 1'b0;

    always @(negedge clk) begin
        ovf_b = 1'b0;
        if (inj_pend) begin
            ovf_b    = 1'b1;
            inj_pend = 1'b0;
        end
        if (inj_req != inj_ack && mem_en && !mem_we && mem_addr == inj_addr) begin
            if (inj_in_rd) ovf_b = 1'b1;
            else           inj_pend = 1'b1;
            inj_ack = inj_req;
        end
    end

    int total = 0;
    int fails = 0;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(int b, int len);
        return 8'((b * 7 + len * 3) & 255);
    endfunction

    function automatic logic [7:0] get_byte(int addr);
        logic [31:0] w;
        w = mem[addr[9:2]];
        return w[addr[1:0]*8 +: 8];
    endfunction

    task automatic host_write(logic [31:0] a, logic [31:0] v);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = v;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic arm(int i);
        host_write(32'(i * 8), 32'(256 + i * 32));
        host_write(32'(i * 8 + 4), 32'h8000_FFF0);
    endtask

    task automatic disarm(int i);
        host_write(32'(i * 8 + 4), 32'h0000_FFF0);
    endtask

    task automatic run_frame(int len, bit fcs, bit drib, int ovf_at);
        for (int b = 0; b < len; b++) begin
            bit acc;
            bit first_try;
            first_try = 1'b1;
            do begin
                @(negedge clk);
                rx_valid   = 1'b1;
                rx_data    = pat(b, len);
                rx_last    = (b == len - 1);
                rx_fcs_err = fcs;
                rx_dribble = drib;
                ovf_a      = first_try && (b == ovf_at);
                first_try  = 1'b0;
                acc        = rx_ready;
                @(posedge clk);
            end while (!acc);
        end
        @(negedge clk);
        rx_valid = 1'b0; rx_last = 1'b0; ovf_a = 1'b0;
        rx_fcs_err = 1'b0; rx_dribble = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic check_buf(int idx, logic [7:0] stat, int nbytes, int off, int len, string req);
        logic [31:0] w1;
        bit ok;
        w1 = mem[idx * 2 + 1];
        check(req, w1, {stat, 8'h00, 16'hFFF0});
        check("R3", 32'(w1[30]), 32'(|w1[29:26]));
        check("R1", mem[idx * 2], 32'(256 + idx * 32));
        check("R6", 32'(wbnum[idx]), 32'd1);
        check("R6", 32'(wbcnt[idx]), 32'(nbytes));
        ok = 1'b1;
        for (int j = 0; j < nbytes; j++)
            if (get_byte(256 + idx * 32 + j) !== pat(off + j, len)) ok = 1'b0;
        check("R2", 32'(ok), 32'd1);
        arm(idx);
    endtask

    typedef struct packed {
        logic [7:0] len;
        logic       fcs;
        logic       drib;
        logic [7:0] last_stat;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd5,  1'b0, 1'b0, 8'h03},
        '{8'd16, 1'b0, 1'b0, 8'h03},
        '{8'd17, 1'b0, 1'b0, 8'h01},
        '{8'd40, 1'b1, 1'b0, 8'h49},
        '{8'd10, 1'b1, 1'b1, 8'h6B},
        '{8'd10, 1'b0, 1'b1, 8'h03},
        '{8'd1,  1'b0, 1'b0, 8'h03},
        '{8'd64, 1'b0, 1'b0, 8'h01}
    };

    initial begin
        #(8 * 150000);
        fails++;
        total++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        int e;
        int m0;
        repeat (3) @(negedge clk);
        check("R12", 32'(rx_ready), 32'd0);
        check("R12", 32'(mem_en), 32'd0);
        check("R7", 32'(missed_frame), 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) arm(i);
        e = 0;

        // table walk: R2, R4, R5, R11
        for (int v = 0; v < 8; v++) begin
            int len;
            int nb;
            string rq;
            len = int'(VECS[v].len);
            nb  = (len + 15) / 16;
            rq  = (VECS[v].fcs || VECS[v].drib) ? "R5" : ((nb > 1) ? "R11" : "R4");
            run_frame(len, VECS[v].fcs, VECS[v].drib, -1);
            for (int k = 0; k < nb; k++) begin
                int nbytes;
                logic [7:0] st;
                nbytes = (len - 16 * k > 16) ? 16 : len - 16 * k;
                st = (k == nb - 1) ? VECS[v].last_stat : ((k == 0) ? 8'h02 : 8'h00);
                check_buf((e + k) % 4, st, nbytes, 16 * k, len, rq);
            end
            e = (e + nb) % 4;
        end

        // R7: host-owned descriptor at frame start
        m0 = miss_cnt;
        disarm(2);
        run_frame(8, 1'b0, 1'b0, -1);
        check("R7", 32'(miss_cnt - m0), 32'd1);
        check("R7", 32'(wbnum[2]), 32'd0);
        check("R7", mem[5], 32'h0000_FFF0);
        arm(2);
        run_frame(5, 1'b0, 1'b0, -1);
        check_buf(2, 8'h03, 5, 0, 5, "R7");

        // R8: next descriptor host-owned while chaining
        m0 = miss_cnt;
        disarm(0);
        run_frame(20, 1'b0, 1'b0, -1);
        check("R8", 32'(wbnum[0]), 32'd0);
        check("R8", mem[1], 32'h0000_FFF0);
        check("R8", 32'(miss_cnt - m0), 32'd0);
        check_buf(3, 8'h46, 16, 0, 20, "R8");
        arm(0);
        run_frame(5, 1'b0, 1'b0, -1);
        check_buf(0, 8'h03, 5, 0, 5, "R8");

        // R9: overflow while storing bytes
        run_frame(30, 1'b0, 1'b0, 5);
        check("R9", 32'(wbnum[2]), 32'd0);
        check_buf(1, 8'h52, 5, 0, 30, "R9");
        run_frame(6, 1'b0, 1'b0, -1);
        check_buf(2, 8'h03, 6, 0, 6, "R9");

        // R10: overflow during the read of an owned next descriptor
        inj_addr = 32'h04; inj_in_rd = 1'b1; inj_req++;
        run_frame(20, 1'b0, 1'b0, -1);
        check("R10", 32'(wbnum[0]), 32'd0);
        check("R10", mem[1], 32'h8000_FFF0);
        check_buf(3, 8'h46, 16, 0, 20, "R10");
        run_frame(5, 1'b0, 1'b0, -1);
        check_buf(0, 8'h03, 5, 0, 5, "R10");

        // R10: overflow in the same cycle a host-owned next is seen
        disarm(2);
        inj_addr = 32'h14; inj_in_rd = 1'b0; inj_req++;
        run_frame(20, 1'b0, 1'b0, -1);
        check("R10", 32'(wbnum[2]), 32'd0);
        check("R10", mem[5], 32'h0000_FFF0);
        check_buf(1, 8'h56, 16, 0, 20, "R10");
        arm(2);
        run_frame(5, 1'b0, 1'b0, -1);
        check_buf(2, 8'h03, 5, 0, 5, "R10");

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule